// File: doc/BRIEF.md
# Register Rename Map and Free List

This block is the rename stage of an out-of-order core. Each instruction arrives with up to two source operands and an optional destination, all given as architectural register names. The block looks up the physical location of each source in a map table indexed by architectural name. For a destination, it takes a fresh physical register from a free list and records it in the map. Because of this, later writers of the same name no longer collide with earlier readers or writers, while true producer-to-consumer links are kept.

Lookup is combinational in the cycle the instruction is presented. The map and free list update at the next rising clock edge. Sources therefore always see the mapping from before the instruction's own destination update. The free list is a queue. At reset it holds the physical registers that the reset mapping leaves unused, in ascending order. Registers returned through the release port join its tail. When the queue is empty, an instruction that needs a destination stalls and leaves all state untouched.

Top module: `rename_stage`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i below ARCH_REGS, and the free list holds physical registers ARCH_REGS to PHYS_REGS-1.
- R2: A non-immediate source operand is renamed to the current map entry of the architectural register named by its low $clog2(ARCH_REGS) bits, zero-extended to the operand width.
- R3: Physical registers are handed out in queue order. From reset, with 4 architectural and 8 physical registers, four consecutive destinations receive p4, p5, p6 and p7.
- R4: A source that names the same register as the instruction's destination receives the mapping from before the instruction.
- R5: A source flagged as immediate is passed to its output unchanged, with no map lookup.
- R6: stall_o is high exactly when valid_i and dest_valid_i are high and the free list is empty. A stalled instruction is not accepted (valid_o low) and changes neither the map nor the free list.
- R7: A released physical register is appended to the tail of the free list and is handed out only after every register already queued.
- R8: A release and an allocation in the same cycle both take effect.
- R9: An instruction with dest_valid_i low allocates no register, never stalls, and leaves the map unchanged.
- R10: While valid_i is low, the map and free list do not change and valid_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is presented |
| dest_valid_i | input | 1 | The instruction writes a destination |
| dest_arch_i | input | ARCH_W | Architectural destination name |
| src_i | input | NUM_SRC x OPND_W | Source operands: register name or immediate |
| src_imm_i | input | NUM_SRC | Per source: operand is an immediate |
| rel_valid_i | input | 1 | Return a physical register to the free list |
| rel_preg_i | input | PHYS_W | Physical register being returned |
| valid_o | output | 1 | Instruction accepted this cycle |
| stall_o | output | 1 | Instruction held because no register is free |
| src_o | output | NUM_SRC x OPND_W | Renamed sources or passed-through immediates |
| dest_preg_o | output | PHYS_W | Newly allocated physical destination |

## Verification
The bench targets four cases. A design that updates the map before the sources are read would rename a read-and-write of the same name to its own new register instead of the old one. A free list that pops while stalled, or while valid_i is low, would skip a register in the later allocation order. A design that drops either side of a simultaneous release and allocation would later hand out the wrong register, or stall too early. A design that treats a release as a stack push would hand the returned register out ahead of older free registers.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned ARCH_REGS_D = 4;
  localparam int unsigned PHYS_REGS_D = 8;
  localparam int unsigned NUM_SRC_D   = 2;
  localparam int unsigned OPND_W_D    = 8;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table
  import rename_pkg::*;
#(
  parameter int unsigned ARCH_REGS = ARCH_REGS_D,
  parameter int unsigned PHYS_REGS = PHYS_REGS_D,
  parameter int unsigned NUM_RD    = NUM_SRC_D,
  localparam int unsigned ARCH_W = idx_w(ARCH_REGS),
  localparam int unsigned PHYS_W = idx_w(PHYS_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_RD-1:0][ARCH_W-1:0]  raddr_i,
  output logic [NUM_RD-1:0][PHYS_W-1:0]  rdata_o,
  input  logic                           we_i,
  input  logic [ARCH_W-1:0]              waddr_i,
  input  logic [PHYS_W-1:0]              wdata_i
);
  logic [PHYS_W-1:0] map_q [ARCH_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PHYS_W'(i);
    end else if (we_i) begin
      map_q[waddr_i] <= wdata_i;
    end
  end

  // reads see pre-update state: same-instruction sources get old mapping
  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rdata_o[g] = map_q[raddr_i[g]];
  end

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> map_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list
  import rename_pkg::*;
#(
  parameter int unsigned ARCH_REGS = ARCH_REGS_D,
  parameter int unsigned PHYS_REGS = PHYS_REGS_D,
  localparam int unsigned DEPTH  = PHYS_REGS - ARCH_REGS,
  localparam int unsigned PHYS_W = idx_w(PHYS_REGS),
  localparam int unsigned PTR_W  = idx_w(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  output logic [PHYS_W-1:0] head_o,
  output logic              empty_o,
  input  logic              push_i,
  input  logic [PHYS_W-1:0] push_preg_i
);
  logic [PHYS_W-1:0] fifo_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) fifo_q[i] <= PHYS_W'(ARCH_REGS + i);
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= CNT_W'(DEPTH);
    end else begin
      if (push_i) begin
        fifo_q[tail_q] <= push_preg_i;
        tail_q         <= bump(tail_q);
      end
      if (pop_i) head_q <= bump(head_q);
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o  = fifo_q[head_q];
  assign empty_o = (count_q == '0);

  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q != '0);
  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> count_q < CNT_W'(DEPTH));
endmodule

// File: rtl/rename_src_port.sv
module rename_src_port
  import rename_pkg::*;
#(
  parameter int unsigned ARCH_REGS = ARCH_REGS_D,
  parameter int unsigned PHYS_REGS = PHYS_REGS_D,
  parameter int unsigned OPND_W    = OPND_W_D,
  localparam int unsigned ARCH_W = idx_w(ARCH_REGS),
  localparam int unsigned PHYS_W = idx_w(PHYS_REGS)
) (
  input  logic [OPND_W-1:0] opnd_i,
  input  logic              imm_i,
  output logic [ARCH_W-1:0] lookup_o,
  input  logic [PHYS_W-1:0] preg_i,
  output logic [OPND_W-1:0] opnd_o
);
  assign lookup_o = opnd_i[ARCH_W-1:0];
  assign opnd_o   = imm_i ? opnd_i : OPND_W'(preg_i);
endmodule

// File: rtl/rename_stage.sv
module rename_stage
  import rename_pkg::*;
#(
  parameter int unsigned ARCH_REGS = ARCH_REGS_D,
  parameter int unsigned PHYS_REGS = PHYS_REGS_D,
  parameter int unsigned NUM_SRC   = NUM_SRC_D,
  parameter int unsigned OPND_W    = OPND_W_D,
  localparam int unsigned ARCH_W = idx_w(ARCH_REGS),
  localparam int unsigned PHYS_W = idx_w(PHYS_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           valid_i,
  input  logic                           dest_valid_i,
  input  logic [ARCH_W-1:0]              dest_arch_i,
  input  logic [NUM_SRC-1:0][OPND_W-1:0] src_i,
  input  logic [NUM_SRC-1:0]             src_imm_i,
  input  logic                           rel_valid_i,
  input  logic [PHYS_W-1:0]              rel_preg_i,
  output logic                           valid_o,
  output logic                           stall_o,
  output logic [NUM_SRC-1:0][OPND_W-1:0] src_o,
  output logic [PHYS_W-1:0]              dest_preg_o
);
  logic                           fl_empty;
  logic [PHYS_W-1:0]              fl_head;
  logic                           alloc;
  logic [NUM_SRC-1:0][ARCH_W-1:0] rd_addr;
  logic [NUM_SRC-1:0][PHYS_W-1:0] rd_data;

  assign stall_o     = valid_i & dest_valid_i & fl_empty;
  assign valid_o     = valid_i & ~stall_o;
  assign alloc       = valid_o & dest_valid_i;
  assign dest_preg_o = fl_head;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    rename_src_port #(
      .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .OPND_W(OPND_W)
    ) u_src (
      .opnd_i  (src_i[g]),
      .imm_i   (src_imm_i[g]),
      .lookup_o(rd_addr[g]),
      .preg_i  (rd_data[g]),
      .opnd_o  (src_o[g])
    );
  end

  rename_map_table #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .NUM_RD(NUM_SRC)
  ) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raddr_i(rd_addr),
    .rdata_o(rd_data),
    .we_i   (alloc),
    .waddr_i(dest_arch_i),
    .wdata_i(fl_head)
  );

  rename_free_list #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)
  ) u_fl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (alloc),
    .head_o     (fl_head),
    .empty_o    (fl_empty),
    .push_i     (rel_valid_i),
    .push_preg_i(rel_preg_i)
  );

  a_r6_stall_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !valid_o);
  a_r9_no_dest_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dest_valid_i) |-> !stall_o);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!valid_o && !stall_o));
endmodule

// File: tb/sim_rename_stage.sv
module sim_rename_stage;
  localparam int unsigned OW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                  valid, dvalid, rel_v;
  logic [1:0]            darch;
  logic [1:0][OW-1:0]    src;
  logic [1:0]            simm;
  logic [2:0]            rel_p;
  logic                  vo, st;
  logic [1:0][OW-1:0]    so;
  logic [2:0]            dp;

  rename_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .dest_valid_i(dvalid),
    .dest_arch_i(darch), .src_i(src), .src_imm_i(simm),
    .rel_valid_i(rel_v), .rel_preg_i(rel_p),
    .valid_o(vo), .stall_o(st), .src_o(so), .dest_preg_o(dp)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]    dst;
    logic          i0;
    logic [OW-1:0] s0;
    logic          i1;
    logic [OW-1:0] s1;
    logic [OW-1:0] e0;
    logic [OW-1:0] e1;
    logic [2:0]    erd;
  } vec_t;

  // add r2,r3->r1 ; sub r2,r1->r3 ; mul r2,r3->r3 ; div r1,#4->r1
  localparam vec_t VEC [4] = '{
    '{2'd1, 1'b0, 8'd2, 1'b0, 8'd3, 8'd2, 8'd3, 3'd4},
    '{2'd3, 1'b0, 8'd2, 1'b0, 8'd1, 8'd2, 8'd4, 3'd5},
    '{2'd3, 1'b0, 8'd2, 1'b0, 8'd3, 8'd2, 8'd5, 3'd6},
    '{2'd1, 1'b0, 8'd1, 1'b1, 8'd4, 8'd4, 8'd4, 3'd7}
  };

  task automatic drive(input logic v, input logic d, input logic [1:0] a,
                       input logic [OW-1:0] s0, input logic i0,
                       input logic [OW-1:0] s1, input logic i1,
                       input logic rv, input logic [2:0] rp);
    @(negedge clk);
    valid = v; dvalid = d; darch = a;
    src[0] = s0; simm[0] = i0; src[1] = s1; simm[1] = i1;
    rel_v = rv; rel_p = rp;
    #1;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    valid = 0; dvalid = 0; darch = 0; src = '0; simm = 0; rel_v = 0; rel_p = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset mapping, read without destination
    drive(1, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R1 r0", so[0], 0); chk("R1 r1", so[1], 1); chk("R9 valid", vo, 1);
    drive(1, 0, 0, 2, 0, 3, 0, 0, 0);
    chk("R1 r2", so[0], 2); chk("R1 r3", so[1], 3);
    // R10: idle cycle with destination request
    drive(0, 1, 2, 0, 0, 0, 0, 0, 0);
    chk("R10 valid_o", vo, 0); chk("R10 stall_o", st, 0);

    // R2 R3 R4 R5: table walk
    for (int k = 0; k < 4; k++) begin
      drive(1, 1, VEC[k].dst, VEC[k].s0, VEC[k].i0, VEC[k].s1, VEC[k].i1, 0, 0);
      chk("R2 src0", so[0], VEC[k].e0);
      chk(VEC[k].i1 ? "R5 imm" : "R2 src1", so[1], VEC[k].e1);
      chk("R3 dest", dp, VEC[k].erd);
      chk("R3 valid", vo, 1);
    end

    // R6: empty list stalls, map untouched (dest r2)
    drive(1, 1, 2, 2, 0, 1, 0, 0, 0);
    chk("R6 stall", st, 1); chk("R6 valid_o", vo, 0);
    // R9: store-like instr, no dest, still flows; R6 r2 still p2
    drive(1, 0, 2, 2, 0, 1, 0, 0, 0);
    chk("R9 stall", st, 0); chk("R9 valid", vo, 1);
    chk("R6 r2 kept", so[0], 2); chk("R4 r1 is p7", so[1], 7);

    // R6: release same cycle as stalled request -> still stalls
    drive(1, 1, 0, 0, 0, 0, 0, 1, 1);
    chk("R6 stall w/ rel", st, 1);
    drive(1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 gets p1", dp, 1); chk("R7 valid", vo, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 1, 2);
    drive(0, 0, 0, 0, 0, 0, 0, 1, 3);
    // R8: alloc p2 and release p0 together -> list [3,0]
    drive(1, 1, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 alloc p2", dp, 2); chk("R4 r0 old p1", so[0], 1);
    drive(1, 1, 3, 0, 0, 0, 0, 0, 0);
    chk("R7 fifo p3", dp, 3); chk("R2 r0 is p2", so[0], 2);
    drive(1, 1, 3, 3, 0, 0, 0, 0, 0);
    chk("R8 rel p0 used", dp, 0); chk("R2 r3 is p3", so[0], 3);
    drive(1, 1, 3, 0, 0, 0, 0, 0, 0);
    chk("R6 empty again", st, 1);

    // R10: release p5, idle with dest request, then one alloc then stall
    drive(0, 1, 1, 0, 0, 0, 0, 1, 5);
    chk("R10 idle valid_o", vo, 0);
    drive(1, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R10 no pop p5", dp, 5); chk("R10 valid", vo, 1);
    drive(1, 1, 1, 1, 0, 0, 0, 0, 0);
    chk("R10 then empty", st, 1); chk("R2 r1 is p5", so[0], 5);

    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule